// File: doc/BRIEF.md
# Additive Harmonic Tone Generator

This block builds one audio sample for every 128 master-clock cycles. It adds up 64 sine harmonics of a fundamental. Each harmonic has its own phase word and its own amplitude. All harmonics share one frequency word. The harmonics are processed one after another in a time-multiplexed loop. Each harmonic gets a two-clock minor cycle, and 64 minor cycles make one major cycle. A single phase adder, one sine function, one pipeline register, one signed multiplier and one accumulator are shared by all 64 harmonics. At the end of each major cycle the finished sum moves into an output register. That register gives a DAC a value that stays constant for the whole of the next major cycle.

A host writes phases, amplitudes and the frequency word through a simple strobe, address and data port. Writes land only in the first clock of each minor cycle, and a strobe that arrives in the second clock is held for one cycle. A pipeline register sits between the sine function and the multiplier, so the amplitude that weights harmonic N is read from amplitude entry N+1 (harmonic 63 uses entry 0). The host must store each amplitude one entry up; the block does not correct for this.

Top module: `additive_tone_gen`

## Requirements
- R1: Counting the first rising edge with reset low as edge 0, edge k is a host edge when k is even and a compute edge when k is odd, and it serves harmonic (k/2) mod 64. The output register is loaded only on compute edges of harmonic 0, that is on edges 1, 129, 257 and so on.
- R2: Synchronous active-high reset clears every phase, every amplitude, the frequency word, the pipeline register, the accumulator and the output to zero.
- R3: The sine value for a 10-bit index i is built as follows. Let x = i mod 512, and let m = floor(x*(512-x)/128) limited to at most 511. The value is +m when bit 9 of i is 0 and -m when bit 9 is 1. The index is the top 10 bits of the 16-bit phase.
- R4: On the compute edge of harmonic h, the sine of the current phase of h is latched, and the phase of h advances by (frequency word × (h+1)) mod 2^16.
- R5: The sine latched for harmonic h is multiplied by amplitude entry (h+1) mod 64, which is read on the next compute edge. Amplitudes are unsigned 8-bit values.
- R6: The sample of a major cycle is the signed sum of all 64 products. A 24-bit accumulator holds it, so 64 products at full scale (±511×255) do not overflow. The accumulator restarts from zero after each transfer.
- R7: The output register keeps its value for all 128 clocks between transfers.
- R8: Host address bits [7:6] select the target: 0 is phase, 1 is amplitude (data bits [7:0]) and 2 is the frequency word. Bits [5:0] select the harmonic. Select 3 writes nothing.
- R9: A strobe sampled on a host edge is committed on that edge. A strobe sampled on a compute edge is committed on the next edge. Strobes must be at least two cycles apart.
- R10: A phase written by the host is used at the next compute edge of that harmonic. A sample whose harmonic slot came before the write still uses the old phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 8 | Target select [7:6] and harmonic index [5:0] |
| hostData | input | 16 | Write data |
| outSample | output | 24 | Signed sample, held for one major cycle |

## Verification
The bench checks the amplitude skew in two ways. It drives a single amplitude on entry 1 and expects only harmonic 0 to sound. It then drives entry 0 and expects harmonic 63, whose term crosses the major-cycle boundary. A design without the skew, or with an extra register to cancel it, would weight the wrong harmonic. The bench drives all 64 harmonics at positive peak and then at negative peak; a narrow or badly sign-extended accumulator would wrap. The bench also commits a frequency write from a strobe on a compute edge, sends writes with select 3, and rewrites a phase in the middle of a major cycle. A design that dropped held strobes, decoded select 3 or applied a phase retroactively would give wrong samples.

// File: rtl/tonegen_pkg.sv
package tonegen_pkg;
  localparam int NUM_HARM    = 64;
  localparam int HARM_W      = $clog2(NUM_HARM);
  localparam int SINE_ADDR_W = 10;
  localparam int SINE_W      = 10;
  localparam int SEL_W       = 2;
  localparam int ADDR_W      = SEL_W + HARM_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_PHASE = 2'd0,
    SEL_AMP   = 2'd1,
    SEL_FREQ  = 2'd2,
    SEL_NONE  = 2'd3
  } hostSel_e;

  typedef struct packed {
    logic              hostSlot;
    logic              calcSlot;
    logic              majorEnd;
    logic [HARM_W-1:0] harm;
  } seqStrb_t;
endpackage

// File: rtl/harmonic_seq_ctrl.sv
module harmonic_seq_ctrl
  import tonegen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  output seqStrb_t strb
);
  logic              subSlot;
  logic [HARM_W-1:0] harmCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      subSlot <= 1'b0;
      harmCnt <= '0;
    end else begin
      subSlot <= ~subSlot;
      if (subSlot) begin
        harmCnt <= (harmCnt == HARM_W'(NUM_HARM - 1)) ? '0 : harmCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.hostSlot = ~subSlot;
    strb.calcSlot = subSlot;
    strb.majorEnd = subSlot && (harmCnt == '0);
    strb.harm     = harmCnt;
  end

  // R1: a minor cycle is a host edge followed by a compute edge
  p_minor_pair_r1: assert property (@(posedge clk) disable iff (rst)
    strb.hostSlot |=> strb.calcSlot);
  p_slot_alternate_r1: assert property (@(posedge clk) disable iff (rst)
    strb.calcSlot |=> strb.hostSlot);
  p_major_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (strb.calcSlot && strb.harm == HARM_W'(NUM_HARM - 1)) |=> (strb.harm == '0));
endmodule

// File: rtl/harmonic_datapath.sv
module harmonic_datapath
  import tonegen_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 8,
  localparam int PROD_W = SINE_W + AMP_W + 1,
  localparam int ACC_W  = SINE_W + AMP_W + HARM_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  seqStrb_t                strb,
  input  logic                    hostWe,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic [PHASE_W-1:0]      hostData,
  output logic signed [ACC_W-1:0] outSample
);
  localparam int SQ_W  = 2 * SINE_ADDR_W;
  localparam int HALF  = 2 ** (SINE_ADDR_W - 1);
  localparam int SHIFT = 2 * SINE_ADDR_W - 4 - (SINE_W - 1);
  localparam int PEAK  = 2 ** (SINE_W - 1) - 1;

  logic [PHASE_W-1:0]      phaseMem [NUM_HARM];
  logic [AMP_W-1:0]        ampMem   [NUM_HARM];
  logic [PHASE_W-1:0]      freqReg;
  logic signed [SINE_W-1:0] sineReg;
  logic signed [ACC_W-1:0] acc;
  logic                    pendValid;
  logic [ADDR_W-1:0]       pendAddr;
  logic [PHASE_W-1:0]      pendData;

  function automatic logic signed [SINE_W-1:0] sineOf(input logic [SINE_ADDR_W-1:0] idx);
    logic [SQ_W-1:0] x;
    logic [SQ_W-1:0] mag;
    logic signed [SINE_W-1:0] v;
    x   = SQ_W'(idx[SINE_ADDR_W-2:0]);
    mag = (x * (SQ_W'(HALF) - x)) >> SHIFT;
    if (mag > SQ_W'(PEAK)) mag = SQ_W'(PEAK);
    v = SINE_W'(mag);
    return idx[SINE_ADDR_W-1] ? -v : v;
  endfunction

  logic                     cmtValid;
  logic [ADDR_W-1:0]        cmtAddr;
  logic [PHASE_W-1:0]       cmtData;
  hostSel_e                 cmtSel;
  logic [HARM_W-1:0]        cmtIdx;
  logic [PHASE_W-1:0]       phaseNow, stepWord;
  logic signed [SINE_W-1:0] sineNow;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt, accNext;

  always_comb begin
    cmtValid = strb.hostSlot && (pendValid || hostWe);
    cmtAddr  = pendValid ? pendAddr : hostAddr;
    cmtData  = pendValid ? pendData : hostData;
    cmtSel   = hostSel_e'(cmtAddr[ADDR_W-1 -: SEL_W]);
    cmtIdx   = cmtAddr[HARM_W-1:0];
    phaseNow = phaseMem[strb.harm];
    stepWord = freqReg * (PHASE_W'(strb.harm) + PHASE_W'(1));
    sineNow  = sineOf(phaseNow[PHASE_W-1 -: SINE_ADDR_W]);
    prod     = $signed(sineReg) * $signed({1'b0, ampMem[strb.harm]});
    prodExt  = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    accNext  = acc + prodExt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_HARM; i++) begin
        phaseMem[i] <= '0;
        ampMem[i]   <= '0;
      end
      freqReg   <= '0;
      sineReg   <= '0;
      acc       <= '0;
      outSample <= '0;
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else begin
      if (strb.hostSlot) begin
        pendValid <= 1'b0;
      end else if (hostWe) begin
        pendValid <= 1'b1;
        pendAddr  <= hostAddr;
        pendData  <= hostData;
      end
      if (cmtValid) begin
        case (cmtSel)
          SEL_PHASE: phaseMem[cmtIdx] <= cmtData;
          SEL_AMP:   ampMem[cmtIdx]   <= cmtData[AMP_W-1:0];
          SEL_FREQ:  freqReg          <= cmtData;
          default:   ;
        endcase
      end
      if (strb.calcSlot) begin
        phaseMem[strb.harm] <= phaseNow + stepWord;
        sineReg             <= sineNow;
        if (strb.majorEnd) begin
          outSample <= accNext;
          acc       <= '0;
        end else begin
          acc <= accNext;
        end
      end
    end
  end

  // R7: output changes only on the transfer edge
  p_out_steady_r7: assert property (@(posedge clk) disable iff (rst)
    !strb.majorEnd |=> $stable(outSample));
  // R6: adding a non-negative product to a non-negative sum never wraps negative
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.calcSlot && !strb.majorEnd && !acc[ACC_W-1] && !prodExt[ACC_W-1]) |=> !acc[ACC_W-1]);
  // R9: a held strobe is always committed on the very next edge, a host edge
  p_pend_slot_r9: assert property (@(posedge clk) disable iff (rst)
    pendValid |-> strb.hostSlot);
  // R9: the frequency word never moves on a compute edge
  p_freq_calm_r9: assert property (@(posedge clk) disable iff (rst)
    strb.calcSlot |=> $stable(freqReg));
endmodule

// File: rtl/additive_tone_gen.sv
module additive_tone_gen
  import tonegen_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 8
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      hostWe,
  input  logic [ADDR_W-1:0]                         hostAddr,
  input  logic [PHASE_W-1:0]                        hostData,
  output logic signed [SINE_W+AMP_W+HARM_W-1:0]     outSample
);
  seqStrb_t strb;

  harmonic_seq_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  harmonic_datapath #(
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .hostWe    (hostWe),
    .hostAddr  (hostAddr),
    .hostData  (hostData),
    .outSample (outSample)
  );
endmodule

// File: tb/additive_tone_gen_test.sv
module additive_tone_gen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        hostWe;
  logic [7:0]  hostAddr;
  logic [15:0] hostData;
  logic signed [23:0] outSample;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastSample = 0;

  typedef struct { int major; int value; string tag; } expItem_t;
  expItem_t q[$];

  int ampTab[64];
  int phTab[64];

  always #4 clk = ~clk;

  additive_tone_gen uut (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .outSample(outSample)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic int sineRef(input int idx);
    int x, y;
    x = idx % 512;
    y = (x * (512 - x)) / 128;
    if (y > 511) y = 511;
    return (idx >= 512) ? -y : y;
  endfunction

  function automatic int expectSample(input int j, input int f);
    int s = 0;
    for (int h = 0; h < 64; h++) begin
      int ph;
      ph = (phTab[h] + j * f * (h + 1)) & 16'hFFFF;
      s += sineRef(ph >> 6) * ampTab[(h + 1) % 64];
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
    @(negedge clk);
  endtask

  // Frequency write timed so that it commits on edge 128*M; returns M
  task automatic alignedFreq(input int f, input bit oddEdge, output int m0);
    int target;
    target = oddEdge ? 127 : 0;
    do @(negedge clk); while ((cyc % 128) != target);
    hostWe = 1'b1; hostAddr = {2'b10, 6'd0}; hostData = 16'(f);
    m0 = (cyc + 1) / 128;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic loadTables;
    hostWrite({2'b10, 6'd0}, 16'd0);
    for (int h = 0; h < 64; h++) begin
      hostWrite({2'b01, 6'(h)}, 16'(ampTab[h]));
      hostWrite({2'b00, 6'(h)}, 16'(phTab[h]));
    end
  endtask

  task automatic runScenario(input int f, input bit oddEdge, input int nMaj,
                             input string tag, input bit injectNone);
    int m0;
    loadTables();
    alignedFreq(f, oddEdge, m0);
    for (int j = 0; j < nMaj; j++) q.push_back('{m0 + j, expectSample(j, f), tag});
    if (injectNone) begin
      hostWrite({2'b11, 6'd5}, 16'hFFFF);   // R8 select 3 must change nothing
      hostWrite({2'b11, 6'd0}, 16'h1234);
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  // Monitor: compares each finished sample one cycle after its transfer edge
  always @(negedge clk) begin
    if (!rst && cyc >= 2 && ((cyc - 2) % 128) == 0) begin
      int m;
      m = (cyc - 2) / 128 - 1;
      if (m < 0) begin
        check(outSample == 0, "R2 first transfer after reset", outSample, 0);
      end else begin
        while (q.size() > 0 && q[0].major < m) begin
          check(1'b0, {q[0].tag, " missed sample"}, 0, q[0].value);
          void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].major == m) begin
          check(int'(outSample) == q[0].value, q[0].tag, outSample, q[0].value);
          void'(q.pop_front());
        end
      end
      lastSample = outSample;
    end
    if (!rst && cyc > 128 && (cyc % 128) == 66)
      check(int'(outSample) == lastSample, "R7 hold mid major", outSample, lastSample);
    if (!rst && cyc > 128 && (cyc % 128) == 1)
      check(int'(outSample) == lastSample, "R1 no early transfer", outSample, lastSample);
  end

  initial begin
    int mw, oldV, newV;
    rst = 1'b1; hostWe = 1'b0; hostAddr = '0; hostData = '0;
    repeat (4) @(negedge clk);
    check(outSample == 0, "R2 reset output", outSample, 0);
    rst = 1'b0;

    // S1: R5 R3 R4 only amplitude entry 1 set, so only harmonic 0 sounds
    for (int h = 0; h < 64; h++) begin ampTab[h] = 0; phTab[h] = (h * 1031) & 16'hFFFF; end
    ampTab[1] = 173; phTab[0] = 16'h1000;
    runScenario(100, 1'b0, 3, "R5 skew harmonic0 / R3 / R4", 1'b0);

    // S2: R5 entry 0 weights harmonic 63 across the boundary
    for (int h = 0; h < 64; h++) ampTab[h] = 0;
    ampTab[0] = 99;
    runScenario(37, 1'b0, 3, "R5 wrap harmonic63 / R4", 1'b0);

    // S3: R6 all at positive peak
    for (int h = 0; h < 64; h++) begin ampTab[h] = 255; phTab[h] = 16'h4000; end
    runScenario(0, 1'b0, 2, "R6 positive full scale", 1'b0);

    // S4: R6 all at negative peak
    for (int h = 0; h < 64; h++) phTab[h] = 16'hC000;
    runScenario(0, 1'b0, 2, "R6 negative full scale", 1'b0);

    // S5: R9 held strobe on an odd edge, R8 select 3 ignored, mixed pattern
    for (int h = 0; h < 64; h++) begin ampTab[h] = (h * 7 + 3) % 256; phTab[h] = (h * 2311) & 16'hFFFF; end
    runScenario(523, 1'b1, 4, "R9 held write / R8 / R4", 1'b1);

    // S6: R10 phase rewrite at minor 10 of a major cycle
    for (int h = 0; h < 64; h++) begin ampTab[h] = 0; phTab[h] = 0; end
    ampTab[6] = 200; phTab[5] = 16'h2000;
    runScenario(0, 1'b0, 1, "R10 before rewrite", 1'b0);
    oldV = expectSample(0, 0);
    phTab[5] = 16'hE000;
    newV = expectSample(0, 0);
    do @(negedge clk); while ((cyc % 128) != 19);
    mw = (cyc + 1) / 128;
    q.push_back('{mw, oldV, "R10 slot already passed"});
    q.push_back('{mw + 1, newV, "R10 next slot uses new phase"});
    hostWrite({2'b00, 6'd5}, 16'hE000);
    while (q.size() > 0) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, queue=%0d expected=0", q.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule